// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block sits between a 16-bit processor core and a single shared address/data bus. The core presents a transfer request. The request carries an address, a direction flag, an address-space flag (memory or I/O), a fetch-kind flag (instruction fetch or data access) and, for a write, the data to write. The sequencer then runs one bus cycle. The address goes out on the shared lines first. The same lines then carry the data. Either phase can be stretched by its own ready input. The core gets a single-clock completion pulse, together with the captured word on reads.

The block does not own the pins. It hands the pad ring a value and an output enable for the shared lines, and a second enable for the strobe and cycle-status lines. When the block does not own the bus, both enables are low and the lines float. A simple grant input stands in for arbitration. A request is taken only while the sequencer is idle and grant is high.

Top module: `mbus_cycle_seq`

## Requirements
- R1: While reset is asserted and in the first idle clock after it, `done` is 0, `rd_data` is 0, `ad_oe` is 0, `addr_valid` is 0, and the status outputs `bus_write`, `bus_io` and `bus_instr` are 0.
- R2: `req_ready` is 1 exactly when the sequencer is idle and `grant` is 1. A request is taken at a rising edge only when `req_valid` and `req_ready` are both 1. With `grant` low, `req_valid` starts no cycle.
- R3: With both ready inputs held high, a cycle lasts exactly four clocks, counted from the clock in which `addr_valid` is 1 up to the clock before `done` is 1. `addr_valid` is 1 only in the first of those clocks. `done` is 1 for exactly one clock, directly after the last clock of the cycle.
- R4: Throughout the address phase (base clocks 1 and 2 plus any address wait clocks), `ad_oe` is 1 and `ad_out` equals the requested address.
- R5: Each clock in which `rdy_addr` is 0 during base clock 2 repeats that clock, so the address phase grows by exactly one clock for each such clock.
- R6: Each clock in which `rdy_data` is 0 during base clock 4 repeats that clock, so the data phase grows by exactly one clock for each such clock.
- R7: On a read (`req_write`=0), `ad_oe` is 0 in every data-phase clock. The value on `ad_in` in the last data clock appears on `rd_data` together with `done`. A write leaves `rd_data` unchanged.
- R8: On a write (`req_write`=1), `ad_oe` is 1 and `ad_out` equals the write data in every data-phase clock.
- R9: Throughout a cycle, `ctl_oe` is 1, and the status outputs are `bus_write`=1 for write / 0 for read, `bus_io`=1 for I/O / 0 for memory, and `bus_instr`=1 for instruction fetch / 0 for data. These values are held unchanged from the first address clock to the last data clock. While idle they are 0.
- R10: While idle, `ad_oe` is 0 and `ctl_oe` follows `grant` combinationally, with no clock edge needed. When grant is low, both enables drop before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant | input | 1 | Bus ownership grant |
| req_valid | input | 1 | Core presents a request |
| req_ready | output | 1 | Idle and granted; request taken at edge |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Word captured on a read |
| ad_out | output | 16 | Value for the shared address/data lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| ad_in | input | 16 | Value seen on the shared lines |
| addr_valid | output | 1 | Address strobe, first clock of a cycle |
| bus_write | output | 1 | Status: write cycle |
| bus_io | output | 1 | Status: I/O cycle |
| bus_instr | output | 1 | Status: instruction fetch |
| ctl_oe | output | 1 | Output enable for strobe and status lines |
| rdy_addr | input | 1 | Address-phase ready; low adds a wait |
| rdy_data | input | 1 | Data-phase ready; low adds a wait |

## Verification
Cycles are run with no waits, with waits only in the address phase, with waits only in the data phase, and with waits in both. Measuring strobe-to-done spacing against four plus the wait count shows which phase each stall lands in. Reads and writes alternate with every mix of the space and fetch flags. This separates a turnaround fault (lines driven during a read) from a status fault, and it shows whether a write disturbs the last read word. Requests made while grant is low, and grant dropped while idle, show that acceptance and the floating of the lines both follow grant.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  parameter int MBUS_W = 16;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_AHOLD = 3'd2,
    PH_TURN  = 3'd3,
    PH_DATA  = 3'd4
  } phase_e;

  typedef struct packed {
    logic [MBUS_W-1:0] addr;
    logic [MBUS_W-1:0] wdata;
    logic              write;
    logic              io;
    logic              instr;
  } xfer_t;

  function automatic logic ph_active(input phase_e ph);
    return ph != PH_IDLE;
  endfunction

  function automatic logic ph_addr_part(input phase_e ph);
    return (ph == PH_ADDR) || (ph == PH_AHOLD);
  endfunction

  function automatic logic ph_data_part(input phase_e ph);
    return (ph == PH_TURN) || (ph == PH_DATA);
  endfunction

  function automatic int cycle_clocks(input int addr_waits, input int data_waits);
    return 4 + addr_waits + data_waits;
  endfunction

endpackage

// File: rtl/mbus_phase_fsm.sv
module mbus_phase_fsm
  import mbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   grant,
  input  logic   req_valid,
  input  logic   rdy_addr,
  input  logic   rdy_data,
  output phase_e phase,
  output logic   req_ready,
  output logic   ev_accept,
  output logic   ev_data_end,
  output logic   done
);

  phase_e ph_q;

  assign phase       = ph_q;
  assign req_ready   = (ph_q == PH_IDLE) && grant;
  assign ev_accept   = req_ready && req_valid;
  assign ev_data_end = (ph_q == PH_DATA) && rdy_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      done <= 1'b0;
    end else begin
      done <= ev_data_end;
      case (ph_q)
        PH_IDLE:  if (ev_accept) ph_q <= PH_ADDR;
        PH_ADDR:  ph_q <= PH_AHOLD;
        PH_AHOLD: if (rdy_addr) ph_q <= PH_TURN;
        PH_TURN:  ph_q <= PH_DATA;
        PH_DATA:  if (rdy_data) ph_q <= PH_IDLE;
        default:  ph_q <= PH_IDLE;
      endcase
    end
  end

  // R5
  addr_wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_AHOLD && !rdy_addr) |=> (ph_q == PH_AHOLD));

  // R6
  data_wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DATA && !rdy_data) |=> (ph_q == PH_DATA && !done));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(ph_q == PH_DATA));

endmodule

// File: rtl/mbus_req_latch.sv
module mbus_req_latch
  import mbus_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  active,
  input  xfer_t req_in,
  output xfer_t cur
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (load) begin
      cur <= req_in;
    end
  end

  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable({cur.write, cur.io, cur.instr, cur.addr}));

endmodule

// File: rtl/mbus_pad_drive.sv
module mbus_pad_drive
  import mbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  xfer_t             cur,
  input  logic              grant,
  input  logic              ev_data_end,
  input  logic [MBUS_W-1:0] ad_in,
  output logic [MBUS_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              addr_valid,
  output logic              bus_write,
  output logic              bus_io,
  output logic              bus_instr,
  output logic              ctl_oe,
  output logic [MBUS_W-1:0] rd_data
);

  logic in_cycle, in_addr, in_data, drive_wdata;

  assign in_cycle    = ph_active(phase);
  assign in_addr     = ph_addr_part(phase);
  assign in_data     = ph_data_part(phase);
  assign drive_wdata = in_data && cur.write;

  always_comb begin
    ad_oe      = in_addr || drive_wdata;
    ad_out     = '0;
    if (in_addr)          ad_out = cur.addr;
    else if (drive_wdata) ad_out = cur.wdata;
    addr_valid = (phase == PH_ADDR);
    ctl_oe     = in_cycle || grant;
    bus_write  = in_cycle && cur.write;
    bus_io     = in_cycle && cur.io;
    bus_instr  = in_cycle && cur.instr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (ev_data_end && !cur.write) begin
      rd_data <= ad_in;
    end
  end

  // R7
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !bus_write) |-> !ad_oe);

  // R10
  idle_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_cycle && !grant) |-> (!ad_oe && !ctl_oe));

  // R9
  status_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_write || bus_io || bus_instr || addr_valid) |-> ctl_oe);

endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq
  import mbus_pkg::*;
#(
  parameter int W = MBUS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         grant,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] req_addr,
  input  logic [W-1:0] req_wdata,
  input  logic         req_write,
  input  logic         req_io,
  input  logic         req_instr,
  output logic         done,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] ad_out,
  output logic         ad_oe,
  input  logic [W-1:0] ad_in,
  output logic         addr_valid,
  output logic         bus_write,
  output logic         bus_io,
  output logic         bus_instr,
  output logic         ctl_oe,
  input  logic         rdy_addr,
  input  logic         rdy_data
);

  phase_e phase;
  logic   ev_accept, ev_data_end;
  xfer_t  req_in, cur;

  assign req_in = '{addr: req_addr, wdata: req_wdata, write: req_write,
                    io: req_io, instr: req_instr};

  mbus_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .grant(grant), .req_valid(req_valid),
    .rdy_addr(rdy_addr), .rdy_data(rdy_data), .phase(phase),
    .req_ready(req_ready), .ev_accept(ev_accept),
    .ev_data_end(ev_data_end), .done(done)
  );

  mbus_req_latch u_latch (
    .clk(clk), .rst_n(rst_n), .load(ev_accept), .active(ph_active(phase)),
    .req_in(req_in), .cur(cur)
  );

  mbus_pad_drive u_pad (
    .clk(clk), .rst_n(rst_n), .phase(phase), .cur(cur), .grant(grant),
    .ev_data_end(ev_data_end), .ad_in(ad_in), .ad_out(ad_out),
    .ad_oe(ad_oe), .addr_valid(addr_valid), .bus_write(bus_write),
    .bus_io(bus_io), .bus_instr(bus_instr), .ctl_oe(ctl_oe),
    .rd_data(rd_data)
  );

  // R2
  strobe_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_valid) |-> ($past(grant) && $past(req_valid)));

  // R4
  addr_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (ad_oe && ctl_oe));

endmodule

// File: tb/mbus_cycle_seq_tb.sv
`timescale 1ns/1ps
module mbus_cycle_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        grant = 1'b0, req_valid = 1'b0;
  logic        req_write = 1'b0, req_io = 1'b0, req_instr = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0, ad_in = 16'h1234;
  logic        rdy_addr = 1'b1, rdy_data = 1'b1;
  logic        req_ready, done, ad_oe, addr_valid, bus_write, bus_io, bus_instr, ctl_oe;
  logic [15:0] rd_data, ad_out;

  always #2.5 clk = ~clk;

  mbus_cycle_seq u_dut (
    .clk(clk), .rst_n(rst_n), .grant(grant), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_write(req_write), .req_io(req_io), .req_instr(req_instr),
    .done(done), .rd_data(rd_data), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .addr_valid(addr_valid), .bus_write(bus_write),
    .bus_io(bus_io), .bus_instr(bus_instr), .ctl_oe(ctl_oe),
    .rdy_addr(rdy_addr), .rdy_data(rdy_data)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  // behavioural reference: clock index within cycle (0 = idle)
  int          m_clk = 0;
  logic [15:0] m_addr = '0, m_wd = '0, m_rd = '0;
  bit          m_w = 0, m_io = 0, m_in = 0, m_done = 0;
  int          aw_left = 0, dw_left = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    m_done = 0;
    if (m_clk == 0) begin
      if (grant && req_valid) begin
        m_addr = req_addr; m_wd = req_wdata;
        m_w = req_write; m_io = req_io; m_in = req_instr;
        m_clk = 1;
      end
    end else if (m_clk == 2) begin
      if (rdy_addr) m_clk = 3;
    end else if (m_clk == 4) begin
      if (rdy_data) begin
        m_clk = 0; m_done = 1;
        if (!m_w) m_rd = ad_in;
      end
    end else begin
      m_clk++;
    end
  endtask

  task automatic compare_all();
    bit busy, exp_oe;
    busy   = (m_clk != 0);
    exp_oe = (m_clk == 1 || m_clk == 2) || (m_clk >= 3 && m_w);
    chk("R2 req_ready", req_ready, !busy && grant);
    chk("R10 ctl_oe", ctl_oe, busy || grant);
    chk("R7 R8 ad_oe", ad_oe, exp_oe);
    if (m_clk == 1 || m_clk == 2) chk("R4 address", ad_out, m_addr);
    if (m_clk >= 3 && m_w)        chk("R8 write data", ad_out, m_wd);
    chk("R3 addr_valid", addr_valid, m_clk == 1);
    chk("R9 bus_write", bus_write, busy && m_w);
    chk("R9 bus_io", bus_io, busy && m_io);
    chk("R9 bus_instr", bus_instr, busy && m_in);
    chk("R3 done", done, m_done);
    chk("R7 rd_data", rd_data, m_rd);
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    ad_in = ad_in + 16'h0111;
    if (m_clk == 1) req_valid = 1'b0;
    rdy_addr = 1'b1; rdy_data = 1'b1;
    if (m_clk == 2 && aw_left > 0) begin rdy_addr = 1'b0; aw_left--; end
    if (m_clk == 4 && dw_left > 0) begin rdy_data = 1'b0; dw_left--; end
  endtask

  task automatic run_cycle(input logic [15:0] a, input bit w, input bit io, input bit ins,
                           input logic [15:0] wd, input int wa, input int wdw);
    int  n = 0;
    bit  started = 0, ended = 0;
    req_addr = a; req_write = w; req_io = io; req_instr = ins; req_wdata = wd;
    req_valid = 1'b1; aw_left = wa; dw_left = wdw;
    for (int k = 0; k < 64 && !ended; k++) begin
      step();
      if (started) begin
        if (done) ended = 1; else n++;
      end else if (addr_valid) begin
        started = 1; n = 1;
      end
    end
    // R3 R5 R6: strobe-to-done spacing is four plus the waits
    chk("R3 R5 R6 cycle length", n, 4 + wa + wdw);
  endtask

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 ad_oe", ad_oe, 0);
    chk("R1 addr_valid", addr_valid, 0);
    chk("R1 status", {bus_write, bus_io, bus_instr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R2: request without grant starts nothing
    req_valid = 1'b1; req_addr = 16'hDEAD;
    repeat (3) step();
    req_valid = 1'b0; grant = 1'b1;
    step();

    run_cycle(16'h0100, 0, 0, 0, 16'h0000, 0, 0);   // memory data read
    run_cycle(16'h0200, 1, 0, 0, 16'hBEEF, 0, 0);   // memory write, rd_data kept (R7)
    run_cycle(16'h0300, 0, 0, 1, 16'h0000, 0, 0);   // instruction fetch
    run_cycle(16'h0040, 1, 1, 0, 16'h5A5A, 0, 0);   // I/O write
    run_cycle(16'h0044, 0, 1, 0, 16'h0000, 2, 0);   // R5 address waits
    run_cycle(16'h0500, 1, 0, 0, 16'hC3C3, 0, 3);   // R6 data waits
    run_cycle(16'h0600, 0, 0, 1, 16'h0000, 1, 1);   // both phases
    run_cycle(16'hFFFF, 0, 1, 1, 16'h0000, 5, 4);   // long stalls
    run_cycle(16'h0000, 1, 1, 1, 16'hFFFF, 3, 0);

    // R10: grant dropped while idle floats at once
    @(negedge clk);
    grant = 1'b0;
    #1;
    chk("R10 ctl_oe float", ctl_oe, 0);
    chk("R10 ad_oe float", ad_oe, 0);
    repeat (2) step();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule